// File: doc/BRIEF.md
# Shared Memory Arbiter with Posted Host Writes

This block shares one external memory bus between two masters. The first is an embedded processor port, which only fetches from flash. The second is a host card-bus port, which reads and writes SRAM. Only one access runs on the bus at a time. Each access lasts one cycle plus the wait-state count programmed for the region it addresses. Between two accesses the bus is idle for one arbitration cycle.

A host write does not wait for the bus. It is captured in a one-entry posted-write buffer, and the host cycle completes in the cycle the strobe is seen. The buffered write is drained to SRAM at the next arbitration, ahead of any other request. A host read is different: WAIT holds the host until the read has actually run on the bus. WAIT drops in the final cycle of the SRAM read, and the read data is valid in that same cycle. The host must hold its strobe, address and data while WAIT is high. It must drop the strobe in the cycle after the one where WAIT was low.

Arbitration rules when the bus is idle:
- A pending posted write goes first.
- Otherwise, when the processor and a host read both request, the port that did not receive the previous grant wins.

Because of these rules, a host read that arrives behind a posted write sits through the drain and then one more processor fetch.

Top module: `shm_arbiter`

## Requirements
- R1: After reset, `host_wait_o`, `mem_req_o` and `cpu_done_o` are low, and the posted-write buffer is empty, so the first host write completes without WAIT.
- R2: Every bus access keeps `mem_req_o` high for exactly 1+N consecutive cycles. N is `flash_ws_i` for a processor fetch and `sram_ws_i` for a host access. The bus is then low for at least one cycle.
- R3: A host write that finds the buffer empty completes in its first strobe cycle with `host_wait_o` low, even while a processor fetch holds the bus.
- R4: A posted write reaches the bus as an SRAM write (`mem_sram_o`=1, `mem_we_o`=1). It carries the captured address and data, and it runs right after the access in progress.
- R5: A host write that finds the buffer full sees `host_wait_o` high until the buffer has drained. It is then accepted, and both writes reach SRAM in arrival order.
- R6: A host read is held with `host_wait_o` high while a posted write is pending.
- R7: For a host read, `host_wait_o` goes low only in the final cycle of its SRAM read (`mem_sram_o`=1, `mem_we_o`=0), and `host_rdata_o` equals the memory data in that cycle. On an idle bus the read sees exactly 1+N WAIT cycles.
- R8: At an idle cycle a pending posted write wins. Otherwise, between a processor fetch and a host read, the port not granted last wins. After reset the processor counts as not granted last.
- R9: `cpu_done_o` is a single-cycle pulse in the final cycle of a flash read (`mem_sram_o`=0), with `cpu_rdata_o` equal to the memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_ws_i | input | WS_W | Wait states for flash accesses |
| sram_ws_i | input | WS_W | Wait states for SRAM accesses |
| cpu_req_i | input | 1 | Processor fetch request, held until done |
| cpu_addr_i | input | AW | Processor fetch address |
| cpu_done_o | output | 1 | Processor fetch completes this cycle |
| cpu_rdata_o | output | DW | Fetch data, valid with `cpu_done_o` |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | AW | Host address |
| host_wdata_i | input | DW | Host write data |
| host_wait_o | output | 1 | Host cycle stalled |
| host_rdata_o | output | DW | Host read data, valid when a read strobe sees WAIT low |
| mem_req_o | output | 1 | Bus access in progress |
| mem_sram_o | output | 1 | 1 selects SRAM, 0 selects flash |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Bus address |
| mem_wdata_o | output | DW | Bus write data |
| mem_rdata_i | input | DW | Bus read data |

## Verification
A wrong wait-state count shows up as an access run of the wrong length on `mem_req_o` within that access. A lost or stale buffer entry shows up as a missing or wrong SRAM write at the next idle cycle. A fairness-state error reorders accesses on the bus one arbitration later. A WAIT error changes the host stall count in the very cycle it occurs. The bench therefore logs every bus access with its kind, length, address and data, and compares the sequence against the expected order.

// File: rtl/shm_arb_pkg.sv
package shm_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_PWR  = 2'd2,
    OWN_HRD  = 2'd3
  } owner_e;
endpackage

// File: rtl/shm_post_buf.sv
module shm_post_buf #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      data_q  <= data_i;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R5: one entry, never overwritten
  p_no_push_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !valid_q);
  // R4: drain only a held entry
  p_pop_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_q);
endmodule

// File: rtl/shm_ws_timer.sv
module shm_ws_timer #(
  parameter int WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            busy_o,
  output logic            done_o
);
  logic            busy_q;
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= ws_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - WS_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_hold_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
  p_gap_after_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q);
endmodule

// File: rtl/shm_grant.sv
module shm_grant
  import shm_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   pw_i,
  input  logic   cpu_i,
  input  logic   rd_i,
  output owner_e gnt_o
);
  logic last_host_q;  // previous grant went to the host side

  always_comb begin
    gnt_o = OWN_NONE;
    if (en_i) begin
      if (pw_i)                 gnt_o = OWN_PWR;
      else if (cpu_i && rd_i)   gnt_o = last_host_q ? OWN_CPU : OWN_HRD;
      else if (cpu_i)           gnt_o = OWN_CPU;
      else if (rd_i)            gnt_o = OWN_HRD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_host_q <= 1'b1;
    else if (gnt_o != OWN_NONE)  last_host_q <= (gnt_o != OWN_CPU);
  end

  p_pw_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pw_i) |-> (gnt_o == OWN_PWR));
  p_no_grant_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (gnt_o == OWN_NONE));
endmodule

// File: rtl/shm_arbiter.sv
module shm_arbiter
  import shm_arb_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WS_W-1:0] flash_ws_i,
  input  logic [WS_W-1:0] sram_ws_i,
  input  logic            cpu_req_i,
  input  logic [AW-1:0]   cpu_addr_i,
  output logic            cpu_done_o,
  output logic [DW-1:0]   cpu_rdata_o,
  input  logic            host_rd_i,
  input  logic            host_wr_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [DW-1:0]   host_wdata_i,
  output logic            host_wait_o,
  output logic [DW-1:0]   host_rdata_o,
  output logic            mem_req_o,
  output logic            mem_sram_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i
);
  logic            buf_valid, buf_push, buf_pop;
  logic [AW-1:0]   buf_addr;
  logic [DW-1:0]   buf_data;
  logic            busy, done, start;
  logic [WS_W-1:0] ws_sel;
  owner_e          gnt, owner_q;
  logic            sram_q, we_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic            rd_done;

  assign rd_done  = done && (owner_q == OWN_HRD);
  assign buf_push = host_wr_i && !buf_valid;
  assign buf_pop  = done && (owner_q == OWN_PWR);

  shm_post_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (buf_push),
    .addr_i  (host_addr_i),
    .data_i  (host_wdata_i),
    .pop_i   (buf_pop),
    .valid_o (buf_valid),
    .addr_o  (buf_addr),
    .data_o  (buf_data)
  );

  shm_grant u_grant (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!busy),
    .pw_i   (buf_valid),
    .cpu_i  (cpu_req_i),
    .rd_i   (host_rd_i),
    .gnt_o  (gnt)
  );

  assign start  = (gnt != OWN_NONE);
  assign ws_sel = (gnt == OWN_CPU) ? flash_ws_i : sram_ws_i;

  shm_ws_timer #(.WS_W(WS_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ws_i    (ws_sel),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      sram_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      owner_q <= gnt;
      sram_q  <= (gnt != OWN_CPU);
      we_q    <= (gnt == OWN_PWR);
      wdata_q <= buf_data;
      case (gnt)
        OWN_CPU: addr_q <= cpu_addr_i;
        OWN_PWR: addr_q <= buf_addr;
        default: addr_q <= host_addr_i;
      endcase
    end
  end

  assign mem_req_o    = busy;
  assign mem_sram_o   = sram_q;
  assign mem_we_o     = we_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
  assign cpu_done_o   = done && (owner_q == OWN_CPU);
  assign cpu_rdata_o  = mem_rdata_i;
  assign host_rdata_o = mem_rdata_i;
  assign host_wait_o  = (host_wr_i && buf_valid) || (host_rd_i && !rd_done);

  p_pw_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && buf_valid) |=> (mem_req_o && mem_we_o && mem_sram_o));
  p_rd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && buf_valid) |-> host_wait_o);
  p_rd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_wait_o) |-> (mem_req_o && mem_sram_o && !mem_we_o));
  p_cpu_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);
  p_cpu_flash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> (mem_req_o && !mem_sram_o));
endmodule

// File: tb/shm_arbiter_tb_top.sv
module shm_arbiter_tb_top;
  localparam int AW = 16, DW = 16, WSW = 3;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [WSW-1:0] flash_ws = '0, sram_ws = '0;
  logic cpu_req = 0, host_rd = 0, host_wr = 0;
  logic [AW-1:0] cpu_addr = '0, host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic cpu_done, host_wait, mem_req, mem_sram, mem_we;
  logic [DW-1:0] cpu_rdata, host_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  assign mem_rdata = mem_addr ^ KEY;

  shm_arbiter #(.AW(AW), .DW(DW), .WS_W(WSW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flash_ws_i(flash_ws), .sram_ws_i(sram_ws),
    .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr), .cpu_done_o(cpu_done),
    .cpu_rdata_o(cpu_rdata), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_wait_o(host_wait),
    .host_rdata_o(host_rdata), .mem_req_o(mem_req), .mem_sram_o(mem_sram),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus access log: kind 0 flash read, 1 SRAM write, 2 SRAM read
  int lg_kind[64], lg_len[64];
  logic [15:0] lg_addr[64], lg_data[64];
  int lg_n = 0, run = 0, cur_kind = 0;
  logic [15:0] cur_addr, cur_data;

  always @(negedge clk) begin
    if (mem_req) begin
      if (run == 0) begin
        cur_kind = !mem_sram ? 0 : (mem_we ? 1 : 2);
        cur_addr = mem_addr;
        cur_data = mem_wdata;
      end
      run++;
    end else if (run > 0) begin
      if (lg_n < 64) begin
        lg_kind[lg_n] = cur_kind; lg_len[lg_n] = run;
        lg_addr[lg_n] = cur_addr; lg_data[lg_n] = cur_data;
      end
      lg_n++;
      run = 0;
    end
  end

  task automatic do_reset();
    rst_n = 0; cpu_req = 0; host_rd = 0; host_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    lg_n = 0; run = 0;
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (mem_req || cpu_req || host_rd || host_wr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_burst(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_req = 1; cpu_addr = base + 16'(i);
      #1;
      while (!cpu_done) begin @(negedge clk); #1; end
      check(cpu_rdata == (cpu_addr ^ KEY), "R9", "fetch data", cpu_rdata, cpu_addr ^ KEY);
      check(!mem_sram, "R9", "done on flash", mem_sram, 0);
    end
    @(negedge clk);
    cpu_req = 0;
    #1 check(!cpu_done, "R9", "done pulse width", cpu_done, 0);
  endtask

  task automatic host_write(input logic [15:0] a, input logic [15:0] d, output int stall);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    #1; stall = 0;
    while (host_wait) begin @(negedge clk); #1; stall++; end
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic host_read(input logic [15:0] a, output logic [15:0] d, output int stall);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #1; stall = 0;
    while (host_wait) begin @(negedge clk); #1; stall++; end
    d = host_rdata;
    check(mem_req && mem_sram && !mem_we, "R7", "release in SRAM read", mem_req, 1);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic t_reset();
    int st;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(!host_wait && !mem_req && !cpu_done, "R1", "outputs in reset",
          {host_wait, mem_req, cpu_done}, 0);
    do_reset();
    #1 check(!host_wait && !mem_req, "R1", "outputs after reset", {host_wait, mem_req}, 0);
    host_write(16'h0001, 16'h0002, st);
    check(st == 0, "R1", "buffer empty after reset", st, 0);
    wait_quiet();
  endtask

  task automatic t_first_grant();
    logic [15:0] d; int st;
    do_reset();
    flash_ws = 1; sram_ws = 1;
    fork
      cpu_burst(1, 16'h0100);
      host_read(16'h0200, d, st);
    join
    wait_quiet();
    check(lg_n == 2, "R8", "access count", lg_n, 2);
    check(lg_kind[0] == 0, "R8", "first grant to processor", lg_kind[0], 0);
    check(lg_kind[1] == 2, "R8", "then host read", lg_kind[1], 2);
    check(d == (16'h0200 ^ KEY), "R7", "read data", d, 16'h0200 ^ KEY);
  endtask

  task automatic t_lengths();
    int st;
    do_reset();
    flash_ws = 0; sram_ws = 5;
    cpu_burst(1, 16'h0300);
    host_write(16'h0310, 16'hA1A1, st);
    wait_quiet();
    flash_ws = 7;
    cpu_burst(1, 16'h0320);
    wait_quiet();
    check(lg_n == 3, "R2", "access count", lg_n, 3);
    check(lg_len[0] == 1, "R2", "flash ws 0 length", lg_len[0], 1);
    check(lg_len[1] == 6, "R2", "sram ws 5 length", lg_len[1], 6);
    check(lg_len[2] == 8, "R2", "flash ws 7 length", lg_len[2], 8);
    check(lg_kind[1] == 1 && lg_addr[1] == 16'h0310 && lg_data[1] == 16'hA1A1,
          "R4", "drained write", lg_data[1], 16'hA1A1);
  endtask

  task automatic t_read_idle();
    logic [15:0] d; int st;
    do_reset();
    sram_ws = 2;
    host_read(16'h0444, d, st);
    wait_quiet();
    check(st == 3, "R7", "idle read wait cycles", st, 3);
    check(d == (16'h0444 ^ KEY), "R7", "idle read data", d, 16'h0444 ^ KEY);
    check(lg_n == 1 && lg_len[0] == 3, "R2", "read length", lg_len[0], 3);
  endtask

  task automatic t_worst();
    logic [15:0] d; int sw, sr;
    do_reset();
    flash_ws = 3; sram_ws = 3;
    fork
      cpu_burst(3, 16'h1000);
      begin
        repeat (2) @(negedge clk);
        host_write(16'h0040, 16'hBEEF, sw);
        host_read(16'h0041, d, sr);
      end
    join
    wait_quiet();
    check(sw == 0, "R3", "posted write stall", sw, 0);
    check(sr > 0, "R6", "read held", sr, 1);
    check(lg_n == 5, "R6", "access count", lg_n, 5);
    check(lg_kind[0] == 0, "R6", "order[0] fetch", lg_kind[0], 0);
    check(lg_kind[1] == 1, "R4", "order[1] drain", lg_kind[1], 1);
    check(lg_kind[2] == 0, "R8", "order[2] fetch", lg_kind[2], 0);
    check(lg_kind[3] == 2, "R6", "order[3] read", lg_kind[3], 2);
    check(lg_kind[4] == 0, "R8", "order[4] fetch", lg_kind[4], 0);
    check(lg_addr[1] == 16'h0040 && lg_data[1] == 16'hBEEF, "R4", "drain content",
          lg_data[1], 16'hBEEF);
    for (int i = 0; i < 5; i++)
      check(lg_len[i] == 4, "R2", "worst-case length", lg_len[i], 4);
    check(d == (16'h0041 ^ KEY), "R7", "held read data", d, 16'h0041 ^ KEY);
  endtask

  task automatic t_full();
    int s1, s2;
    do_reset();
    flash_ws = 7; sram_ws = 0;
    fork
      cpu_burst(1, 16'h2000);
      begin
        repeat (2) @(negedge clk);
        host_write(16'h0010, 16'h1111, s1);
        host_write(16'h0011, 16'h2222, s2);
      end
    join
    wait_quiet();
    check(s1 == 0, "R3", "first write", s1, 0);
    check(s2 > 0, "R5", "second write stalled", s2, 1);
    check(lg_n == 3, "R5", "access count", lg_n, 3);
    check(lg_kind[1] == 1 && lg_data[1] == 16'h1111 && lg_addr[1] == 16'h0010,
          "R5", "first drain", lg_data[1], 16'h1111);
    check(lg_kind[2] == 1 && lg_data[2] == 16'h2222 && lg_addr[2] == 16'h0011,
          "R5", "second drain", lg_data[2], 16'h2222);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_first_grant();
    t_lengths();
    t_read_idle();
    t_worst();
    t_full();
    finish_run();
  end
endmodule